// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block checks the integrity of a 64-bit device identifier that arrives one bit per strobe, least significant bit first. It runs an 8-bit cyclic redundancy check over the lower 56 bits of the identifier, which carry the family code and serial number. It collects the upper 8 bits, which carry the stored check byte, and compares the two bytes directly. The stored byte is in true form, so no inversion is applied.

A frame begins after reset or after a one-cycle `start_i` pulse. The source then presents bits on `bit_i` and qualifies each one with `bit_vld_i`. Idle cycles between strobes are allowed. When the sixty-fourth bit is taken, `done_o` pulses for one cycle. `match_o` gives the verdict on that cycle and holds it until the next start or reset. Strobes that arrive after the frame is complete are ignored.

Top module: `id_crc8_check`

## Requirements
- R1: While `rst` is high at a clock edge, `done_o` and `match_o` are both 0 after that edge, and the bit position returns to zero.
- R2: `done_o` goes high for exactly one cycle. It is registered, so it is visible in the cycle right after the edge at which the 64th strobed bit (bit index 63) is taken.
- R3: The check uses the polynomial x^8+x^5+x^4+1. It is processed in reflected form (constant 0x8C), starts from 0x00, takes bits 0..55 least significant first, and applies no final inversion. `match_o` is 1 on the `done_o` cycle when this result equals identifier bits 63..56. Bit 56 is the least significant bit of the stored byte.
- R4: `match_o` is 0 on the `done_o` cycle when the stored byte differs from the computed one. This includes a stored byte that equals the bitwise inverse of the computed value, and a single corrupted payload bit.
- R5: After `done_o`, `match_o` keeps its value until `start_i` or `rst` is asserted, whatever `bit_vld_i` and `bit_i` do in between.
- R6: A cycle with `bit_vld_i` low does not advance the frame, whatever `bit_i` holds. Strobes after bit 63 are ignored: they produce no second `done_o` and no change of `match_o`.
- R7: `start_i` clears `done_o` and `match_o` and restarts the frame at bit 0. If `start_i` and `bit_vld_i` are high in the same cycle, `start_i` wins and that bit is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Clears the verdict and begins a new frame |
| bit_vld_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Identifier bit, least significant first |
| done_o | output | 1 | One-cycle pulse after bit 63 is taken |
| match_o | output | 1 | Stored check byte equals the computed one; valid from `done_o` on |

## Verification
Two functions can fall in the same cycle: a frame restart and the acceptance of an identifier bit. The bench provokes this by driving `start_i` together with `bit_vld_i` when 63 bits have already been taken. If that bit were accepted, it would complete the frame. The collision is judged correct when no `done_o` follows. A later full good identifier must then give `done_o` only after all 64 of its own bits, with `match_o` high, which shows the discarded bit left no trace in the count or in the check register.

// File: rtl/id_crc_pkg.sv
package id_crc_pkg;

  localparam int unsigned ID_BITS_DEF = 64;
  localparam int unsigned CRC_W_DEF   = 8;

  // One serial step of a reflected CRC: shift right, fold in poly on feedback.
  function automatic logic [CRC_W_DEF-1:0] crc_step(
    input logic [CRC_W_DEF-1:0] cur,
    input logic                 din,
    input logic [CRC_W_DEF-1:0] poly
  );
    logic fb;
    fb = cur[0] ^ din;
    crc_step = (cur >> 1) ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/id_bit_counter.sv
module id_bit_counter #(
  parameter int unsigned ID_BITS   = 64,
  parameter int unsigned DATA_BITS = 56,
  localparam int unsigned CNT_W    = $clog2(ID_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             bit_vld_i,
  output logic             take_o,
  output logic             data_phase_o,
  output logic             last_take_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(ID_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ID_BITS - 1);
  localparam logic [CNT_W-1:0] DLIM = CNT_W'(DATA_BITS);

  logic [CNT_W-1:0] cnt_q;

  assign take_o       = bit_vld_i && !start_i && (cnt_q != FULL);
  assign data_phase_o = (cnt_q < DLIM);
  assign last_take_o  = take_o && (cnt_q == LAST);
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) cnt_q <= '0;
    else if (take_o)    cnt_q <= cnt_q + 1'b1;
  end

  // R6: the position never runs past a complete frame
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  // R6: no strobe, no movement
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld_i && !start_i) |=> $stable(cnt_q));
  // R7: start returns the position to zero
  a_r7_cnt_restart: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == '0));

endmodule

// File: rtl/crc_serial.sv
module crc_serial
  import id_crc_pkg::*;
#(
  parameter logic [CRC_W_DEF-1:0] POLY = 8'h8C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 din_i,
  output logic [CRC_W_DEF-1:0] crc_o
);

  logic [CRC_W_DEF-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) crc_q <= '0;
    else if (en_i)    crc_q <= crc_step(crc_q, din_i, POLY);
  end

  assign crc_o = crc_q;

  // R6: register holds when no data bit is taken
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(crc_q));
  // R3: clear brings the register to its zero seed
  a_r3_crc_seed: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (crc_q == '0));

endmodule

// File: rtl/byte_capture.sv
module byte_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_next_o
);

  logic [W-1:0] q_r;

  // LSB-first arrival: newest bit enters at the top
  generate
    if (W > 1) begin : g_wide
      assign q_next_o = {din_i, q_r[W-1:1]};
    end else begin : g_one
      assign q_next_o = din_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr_i) q_r <= '0;
    else if (en_i)    q_r <= q_next_o;
  end

  assign q_o = q_r;

  // R6: captured byte holds without a tail-phase strobe
  a_r6_cap_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(q_r));

endmodule

// File: rtl/id_crc8_check.sv
module id_crc8_check
  import id_crc_pkg::*;
#(
  parameter int unsigned          ID_BITS = ID_BITS_DEF,
  parameter logic [CRC_W_DEF-1:0] POLY    = 8'h8C
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic done_o,
  output logic match_o
);

  localparam int unsigned CRC_W     = CRC_W_DEF;
  localparam int unsigned DATA_BITS = ID_BITS - CRC_W;
  localparam int unsigned CNT_W     = $clog2(ID_BITS + 1);

  logic             take, data_phase, last_take;
  logic [CNT_W-1:0] cnt;
  logic [CRC_W-1:0] crc_val, cap_val, cap_next;

  id_bit_counter #(.ID_BITS(ID_BITS), .DATA_BITS(DATA_BITS)) u_cnt (
    .clk(clk), .rst(rst), .start_i(start_i), .bit_vld_i(bit_vld_i),
    .take_o(take), .data_phase_o(data_phase), .last_take_o(last_take),
    .cnt_o(cnt)
  );

  crc_serial #(.POLY(POLY)) u_crc (
    .clk(clk), .rst(rst), .clr_i(start_i),
    .en_i(take && data_phase), .din_i(bit_i), .crc_o(crc_val)
  );

  byte_capture #(.W(CRC_W)) u_cap (
    .clk(clk), .rst(rst), .clr_i(start_i),
    .en_i(take && !data_phase), .din_i(bit_i),
    .q_o(cap_val), .q_next_o(cap_next)
  );

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      done_o <= last_take;
      if (last_take) match_o <= (crc_val == cap_next);
    end
  end

  // R1: synchronous reset clears both outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!done_o && !match_o));
  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R2: done follows the final bit and nothing else
  a_r2_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(last_take));
  // R5: verdict frozen outside the final-bit edge
  a_r5_match_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !last_take) |=> $stable(match_o));
  // R7: start wipes the verdict
  a_r7_start_clear: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!done_o && !match_o));
  // R3: final bit arrives only with the count at the last position
  a_r3_last_pos: assert property (@(posedge clk) disable iff (rst)
    last_take |-> (cnt == CNT_W'(ID_BITS - 1)) && !data_phase);
  // R6: the capture byte is unused before the tail phase
  a_r6_cap_idle: assert property (@(posedge clk) disable iff (rst)
    (data_phase && !start_i) |-> (cap_val == '0));

endmodule

// File: tb/sim_id_crc8_check.sv
module sim_id_crc8_check;

  logic clk = 1'b0;
  logic rst, start_i, bit_vld_i, bit_i;
  logic done_o, match_o;
  int   checks = 0;
  int   fails  = 0;
  bit   ended  = 1'b0;

  always #5 clk = ~clk;

  id_crc8_check u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .bit_vld_i(bit_vld_i),
    .bit_i(bit_i), .done_o(done_o), .match_o(match_o)
  );

  localparam int NV = 7;
  localparam logic [55:0] PAY [NV] = '{
    56'h0, 56'hFFFFFFFFFFFFFF, 56'h00000001B81C02, 56'h123456789ABCDE,
    56'h00000001B81C02, 56'hA5A5A5A5A5A5A5, 56'h00000001B81C03 };
  localparam logic [7:0]  CMSK [NV] = '{
    8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h01, 8'h00 };
  localparam logic [55:0] PFLIP [NV] = '{
    56'h0, 56'h0, 56'h0, 56'h0, 56'h0, 56'h0, 56'h1 };
  localparam bit EXPM [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1; bit_vld_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
  endtask

  // Sends n bits of id starting at bit 0; gap idle cycles (with bit_i toggling) between strobes.
  task automatic send_bits(input logic [63:0] id, input int n, input int gap, output bit early);
    early = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (done_o) early = 1'b1;
        bit_vld_i = 1'b0; bit_i = ~bit_i;
      end
      @(negedge clk);
      if (done_o) early = 1'b1;
      bit_vld_i = 1'b1; bit_i = id[i];
    end
  endtask

  task automatic run_frame(input logic [63:0] id, input bit expm, input int gap, input string tag);
    bit early;
    pulse_start();
    chk(!match_o && !done_o, "R7 start clears", int'(match_o), 0);
    send_bits(id, 64, gap, early);
    @(negedge clk); bit_vld_i = 1'b0;
    chk(!early, {"R2 no early done ", tag}, int'(early), 0);
    chk(done_o == 1'b1, {"R2 done after bit 63 ", tag}, int'(done_o), 1);
    chk(match_o == expm, {expm ? "R3 match " : "R4 mismatch ", tag}, int'(match_o), int'(expm));
    @(negedge clk); bit_i = ~bit_i;
    chk(done_o == 1'b0, {"R2 single pulse ", tag}, int'(done_o), 0);
    repeat (3) @(negedge clk);
    chk(match_o == expm, {"R5 verdict held ", tag}, int'(match_o), int'(expm));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] id;
    bit          early;
    bit          held;
    rst = 1'b1; start_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done_o && !match_o, "R1 reset state", int'({done_o, match_o}), 0);
    rst = 1'b0;

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [55:0] p;
      p  = PAY[v];
      id = {ref_crc(p) ^ CMSK[v], p ^ PFLIP[v]};
      run_frame(id, EXPM[v], v % 3, $sformatf("vec%0d", v));
    end

    // R3: a known-good identifier written out literally
    run_frame(64'hA200000001B81C02, 1'b1, 0, "literal");

    // R6: strobes after bit 63 are ignored
    held = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done_o || !match_o) held = 1'b0;
      bit_vld_i = 1'b1; bit_i = k[0];
    end
    @(negedge clk); bit_vld_i = 1'b0;
    if (done_o || !match_o) held = 1'b0;
    chk(held, "R6 extra strobes ignored", int'({done_o, match_o}), 1);

    // R7: start collides with what would be bit 63
    id = {ref_crc(56'h00000001B81C02), 56'h00000001B81C02};
    pulse_start();
    send_bits(id, 63, 0, early);
    @(negedge clk); start_i = 1'b1; bit_vld_i = 1'b1; bit_i = id[63];
    @(negedge clk); start_i = 1'b0; bit_vld_i = 1'b0;
    chk(!done_o && !early, "R7 start wins over strobe", int'(done_o), 0);
    send_bits(id, 64, 0, early);
    @(negedge clk); bit_vld_i = 1'b0;
    chk(!early && done_o && match_o, "R7 fresh frame after collision",
        int'({early, done_o, match_o}), 3);

    // R5: verdict survives a long idle run, then R1 reset clears it
    repeat (10) @(negedge clk);
    chk(match_o == 1'b1, "R5 verdict held idle", int'(match_o), 1);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!match_o && !done_o, "R1 reset clears verdict", int'(match_o), 0);

    // R6: after reset with no start, a good frame with wide gaps still completes
    send_bits(id, 64, 4, early);
    @(negedge clk); bit_vld_i = 1'b0;
    chk(!early && done_o && match_o, "R6 gaps do not advance frame",
        int'({early, done_o, match_o}), 3);

    if (!ended) begin
      ended = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule